// File: doc/BRIEF.md
# Function Configuration Header Register File

This block keeps the 64-byte configuration header of a single bus function. All fields come from parameters at reset. That covers the vendor and device identity, revision and class code, header type, six base address windows, the expansion ROM window, the interrupt routing bytes and the timing bytes. After reset a host reads and updates the header through a simple request port. Each request carries a byte offset, an access width of 1, 2 or 4 bytes, a write flag and write data. The block answers every request one clock later with read data and an error flag.

Only a few fields take writes, and which ones depends on the access width. Every other write is refused with the error flag and leaves the header unchanged. The six base address registers support the usual sizing handshake. Writing all ones makes a register report its window size as a mask, and its low type bits stay fixed throughout. The expansion ROM register has its own probe value. Reads at any offset return the stored bytes in little-endian lane order. Bytes past the end of the header read as zero.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset every header byte holds its parameter value: vendor id at byte 0x00, device id at 0x02, command at 0x04, status at 0x06, revision at 0x08, class code at 0x09-0x0B, cache line size at 0x0C, latency at 0x0D, header type at 0x0E, self-test at 0x0F, base address register k at 0x10+4k, card info pointer at 0x28, subsystem vendor at 0x2C, subsystem id at 0x2E, ROM base at 0x30, interrupt line at 0x3C, interrupt pin at 0x3D, min grant at 0x3E and max latency at 0x3F. Every request made in cycle n gets rsp_valid high in cycle n+1, and rsp_valid is low in a cycle after no request.
- R2: A read of width 1, 2 or 4 returns byte offset+i on rsp_rdata[8i+7:8i] and zero on unused lanes. Any byte whose address is 64 or more reads as zero, and the read raises no error.
- R3: A 1-byte write is accepted only at 0x3C and 0x0C, and it replaces that one byte.
- R4: A 2-byte write is accepted only at 0x04, 0x06 and 0x0C. It replaces the byte at the offset and the byte after it, so a halfword at 0x0C also updates 0x0D.
- R5: A 4-byte write at 0x04 replaces only the command halfword with the low 16 data bits. The status bytes at 0x06-0x07 keep their value.
- R6: A 4-byte write to a base address register (0x10, 0x14, 0x18, 0x1C, 0x20, 0x24) with data other than 0xFFFFFFFF stores the data above the type bits. The type bits are bits 1:0 when bit 0 of the register is 1, and bits 3:0 otherwise. Those bits keep their old value.
- R7: A 4-byte write of 0xFFFFFFFF to a base address register loads ~(size-1) above the type bits. size is that register's power-of-two window parameter, and the type bits are kept.
- R8: A 4-byte write to 0x30 stores the data unchanged, except that the value 0xFFFFFFFE is stored as 0xFFFFFFFF.
- R9: Any other write is refused with rsp_err high and leaves all 64 bytes unchanged. This covers every offset and width not listed in R3 to R8, and every offset of 64 or more.
- R10: A request whose width is not 1, 2 or 4 (read or write) gets rsp_err high and rsp_rdata zero, and changes nothing.
- R11: An accepted write answers with rsp_err low, and every write answers with rsp_rdata zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access width in bytes |
| acc_wdata | input | 32 | Write data, lane 0 = lowest byte |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request refused or malformed |

## Verification
The hardest state to reach is a base address register whose type bits must survive a write that has been refused or a sizing probe. Only a narrow set of legal writes reaches these registers, and most random traffic is refused. The stimulus therefore draws a quarter of its offsets from the list of writable offsets and biases write data toward the two probe values. Random sizing probes, normal writes and misaligned or wrong-width attempts hit the same registers in varying order, and each one is compared with a bench model of the header.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
    localparam int HDR_BYTES = 64;
    localparam int NUM_BARS  = 6;
    localparam int LANES     = 4;

    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h06;
    localparam logic [7:0] OFS_CLS   = 8'h0C;
    localparam logic [7:0] OFS_BAR0  = 8'h10;
    localparam logic [7:0] OFS_ROM   = 8'h30;
    localparam logic [7:0] OFS_INTLN = 8'h3C;
    localparam logic [7:0] BAR_END   = OFS_BAR0 + 8'(4 * NUM_BARS);

    localparam logic [31:0] PROBE_ALL  = 32'hFFFF_FFFF;
    localparam logic [31:0] PROBE_ROM  = 32'hFFFF_FFFE;

    typedef logic [HDR_BYTES-1:0][7:0] hdr_t;

    typedef enum logic [2:0] {
        WR_REJECT,
        WR_BYTE,
        WR_HALF,
        WR_CMD_WORD,
        WR_BAR,
        WR_ROM
    } wr_kind_e;

    typedef struct packed {
        hdr_t        hdr;
        logic        rsp_valid;
        logic [31:0] rdata;
        logic        err;
    } state_t;
endpackage

// File: rtl/cfg_hdr_wr_decode.sv
module cfg_hdr_wr_decode
    import cfg_hdr_pkg::*;
(
    input  logic [7:0] offset,
    input  logic [2:0] size,
    output wr_kind_e   kind,
    output logic [2:0] bar_sel
);
    logic [7:0] rel;
    logic       in_bar;

    always_comb begin
        rel     = offset - OFS_BAR0;
        bar_sel = rel[4:2];
        in_bar  = (offset >= OFS_BAR0) && (offset < BAR_END) && (offset[1:0] == 2'b00);
        kind    = WR_REJECT;
        unique case (size)
            3'd1: begin
                if (offset == OFS_INTLN || offset == OFS_CLS)
                    kind = WR_BYTE;
            end
            3'd2: begin
                if (offset == OFS_CMD || offset == OFS_STAT || offset == OFS_CLS)
                    kind = WR_HALF;
            end
            3'd4: begin
                if (in_bar)
                    kind = WR_BAR;
                else if (offset == OFS_ROM)
                    kind = WR_ROM;
                else if (offset == OFS_CMD)
                    kind = WR_CMD_WORD;
            end
            default: kind = WR_REJECT;
        endcase
    end
endmodule

// File: rtl/cfg_hdr_bar_update.sv
module cfg_hdr_bar_update
    import cfg_hdr_pkg::*;
(
    input  logic [31:0] old_val,
    input  logic [31:0] wdata,
    input  logic [31:0] size_m1,
    output logic [31:0] new_val
);
    logic [31:0] type_mask;
    logic [31:0] src;

    always_comb begin
        // I/O windows fix two low bits, memory windows fix four
        type_mask = old_val[0] ? 32'h0000_0003 : 32'h0000_000F;
        src       = (wdata == PROBE_ALL) ? ~size_m1 : wdata;
        new_val   = (src & ~type_mask) | (old_val & type_mask);
    end
endmodule

// File: rtl/cfg_hdr_rd_mux.sv
module cfg_hdr_rd_mux
    import cfg_hdr_pkg::*;
(
    input  hdr_t        hdr,
    input  logic [7:0]  offset,
    input  logic [2:0]  size,
    output logic [31:0] rdata
);
    logic [LANES-1:0][7:0] lanes;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [8:0] addr;
        always_comb begin
            addr = {1'b0, offset} + 9'(g);
            if (addr < 9'(HDR_BYTES) && 3'(g) < size)
                lanes[g] = hdr[addr[5:0]];
            else
                lanes[g] = 8'h00;
        end
    end

    assign rdata = lanes;
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]  VENDOR_ID   = 16'h1234,
    parameter logic [15:0]  DEVICE_ID   = 16'h5678,
    parameter logic [15:0]  CMD_INIT    = 16'h0000,
    parameter logic [15:0]  STAT_INIT   = 16'h0000,
    parameter logic [7:0]   REVISION    = 8'h01,
    parameter logic [23:0]  CLASS_CODE  = 24'h020000,
    parameter logic [7:0]   CLS_INIT    = 8'h00,
    parameter logic [7:0]   LAT_INIT    = 8'h00,
    parameter logic [7:0]   HDR_TYPE    = 8'h00,
    parameter logic [7:0]   BIST_INIT   = 8'h00,
    parameter logic [6*32-1:0] BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0},
    parameter logic [6*32-1:0] BAR_SIZE = {32'd16, 32'd16, 32'd16, 32'd16, 32'd32, 32'd4096},
    parameter logic [31:0]  CIS_INIT    = 32'h0,
    parameter logic [15:0]  SUBSYS_VID  = 16'h0000,
    parameter logic [15:0]  SUBSYS_ID   = 16'h0000,
    parameter logic [31:0]  ROM_INIT    = 32'h0,
    parameter logic [7:0]   INT_LINE    = 8'h00,
    parameter logic [7:0]   INT_PIN     = 8'h01,
    parameter logic [7:0]   MIN_GNT     = 8'h00,
    parameter logic [7:0]   MAX_LAT     = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [7:0]  acc_offset,
    input  logic [2:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err
);
    function automatic hdr_t build_init();
        hdr_t h;
        h        = '0;
        h[8'h00] = VENDOR_ID[7:0];
        h[8'h01] = VENDOR_ID[15:8];
        h[8'h02] = DEVICE_ID[7:0];
        h[8'h03] = DEVICE_ID[15:8];
        h[8'h04] = CMD_INIT[7:0];
        h[8'h05] = CMD_INIT[15:8];
        h[8'h06] = STAT_INIT[7:0];
        h[8'h07] = STAT_INIT[15:8];
        h[8'h08] = REVISION;
        h[8'h09] = CLASS_CODE[7:0];
        h[8'h0A] = CLASS_CODE[15:8];
        h[8'h0B] = CLASS_CODE[23:16];
        h[8'h0C] = CLS_INIT;
        h[8'h0D] = LAT_INIT;
        h[8'h0E] = HDR_TYPE;
        h[8'h0F] = BIST_INIT;
        for (int k = 0; k < NUM_BARS; k++)
            for (int b = 0; b < 4; b++)
                h[16 + 4*k + b] = BAR_INIT[32*k + 8*b +: 8];
        for (int b = 0; b < 4; b++) begin
            h[8'h28 + b] = CIS_INIT[8*b +: 8];
            h[8'h30 + b] = ROM_INIT[8*b +: 8];
        end
        h[8'h2C] = SUBSYS_VID[7:0];
        h[8'h2D] = SUBSYS_VID[15:8];
        h[8'h2E] = SUBSYS_ID[7:0];
        h[8'h2F] = SUBSYS_ID[15:8];
        h[8'h3C] = INT_LINE;
        h[8'h3D] = INT_PIN;
        h[8'h3E] = MIN_GNT;
        h[8'h3F] = MAX_LAT;
        return h;
    endfunction

    localparam hdr_t   HDR_INIT  = build_init();
    localparam state_t RST_STATE = '{hdr: HDR_INIT, rsp_valid: 1'b0, rdata: 32'h0, err: 1'b0};

    state_t      cur_q;
    state_t      nxt_d;

    wr_kind_e    wr_kind;
    logic [2:0]  bar_sel;
    logic [5:0]  idx;
    logic [31:0] old_word;
    logic [31:0] size_m1;
    logic [31:0] bar_new;
    logic [31:0] rom_new;
    logic [31:0] rd_word;
    logic        size_ok;

    cfg_hdr_wr_decode u_dec (
        .offset  (acc_offset),
        .size    (acc_size),
        .kind    (wr_kind),
        .bar_sel (bar_sel)
    );

    cfg_hdr_bar_update u_bar (
        .old_val (old_word),
        .wdata   (acc_wdata),
        .size_m1 (size_m1),
        .new_val (bar_new)
    );

    cfg_hdr_rd_mux u_rd (
        .hdr    (cur_q.hdr),
        .offset (acc_offset),
        .size   (acc_size),
        .rdata  (rd_word)
    );

    always_comb begin
        idx      = acc_offset[5:0];
        old_word = {cur_q.hdr[idx + 6'd3], cur_q.hdr[idx + 6'd2],
                    cur_q.hdr[idx + 6'd1], cur_q.hdr[idx]};
        size_m1  = 32'h0;
        for (int k = 0; k < NUM_BARS; k++)
            if (bar_sel == 3'(k))
                size_m1 = BAR_SIZE[32*k +: 32] - 32'd1;
        rom_new  = (acc_wdata == PROBE_ROM) ? PROBE_ALL : acc_wdata;
        size_ok  = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
    end

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.rsp_valid = acc_valid;
        nxt_d.rdata     = 32'h0;
        nxt_d.err       = 1'b0;
        if (acc_valid) begin
            if (acc_write) begin
                unique case (wr_kind)
                    WR_BYTE: begin
                        nxt_d.hdr[idx] = acc_wdata[7:0];
                    end
                    WR_HALF: begin
                        nxt_d.hdr[idx]        = acc_wdata[7:0];
                        nxt_d.hdr[idx + 6'd1] = acc_wdata[15:8];
                    end
                    WR_CMD_WORD: begin
                        nxt_d.hdr[idx]        = acc_wdata[7:0];
                        nxt_d.hdr[idx + 6'd1] = acc_wdata[15:8];
                    end
                    WR_BAR: begin
                        for (int b = 0; b < 4; b++)
                            nxt_d.hdr[idx + 6'(b)] = bar_new[8*b +: 8];
                    end
                    WR_ROM: begin
                        for (int b = 0; b < 4; b++)
                            nxt_d.hdr[idx + 6'(b)] = rom_new[8*b +: 8];
                    end
                    default: nxt_d.err = 1'b1;
                endcase
            end else if (size_ok) begin
                nxt_d.rdata = rd_word;
            end else begin
                nxt_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= RST_STATE;
        else
            cur_q <= nxt_d;
    end

    assign rsp_valid = cur_q.rsp_valid;
    assign rsp_rdata = cur_q.rdata;
    assign rsp_err   = cur_q.err;
endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk #(
    parameter logic [15:0] VID = 16'h0,
    parameter logic [15:0] DID = 16'h0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_offset,
    input logic [2:0]  acc_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err
);
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    p_high_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_offset >= 8'd64) |=> (rsp_rdata == 32'h0));

    p_ident_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_offset == 8'h00 && acc_size == 3'd4)
        |=> (rsp_rdata == {DID, VID} && !rsp_err));

    p_high_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset >= 8'd64) |=> rsp_err);

    p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_size == 3'd3 || acc_size == 3'd0)) |=> (rsp_err && rsp_rdata == 32'h0));

    p_write_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (rsp_rdata == 32'h0));
endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(.VID(VENDOR_ID), .DID(DEVICE_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_offset (acc_offset),
    .acc_size   (acc_size),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
);

// File: tb/cfg_hdr_regs_bench.sv
`timescale 1ns/1ps
module cfg_hdr_regs_bench;
    localparam logic [15:0] T_VID   = 16'h1A2B;
    localparam logic [15:0] T_DID   = 16'h3C4D;
    localparam logic [15:0] T_CMD   = 16'h0006;
    localparam logic [15:0] T_STAT  = 16'h0210;
    localparam logic [7:0]  T_REV   = 8'h05;
    localparam logic [23:0] T_CLASS = 24'h0C0330;
    localparam logic [6*32-1:0] T_BINIT = {32'h0, 32'h1, 32'h0, 32'h4, 32'h1, 32'h8};
    localparam logic [6*32-1:0] T_BSZ   = {32'd1024, 32'd64, 32'd16, 32'd256, 32'd32, 32'd4096};
    localparam logic [31:0] T_ROM   = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = 8'h0;
    logic [2:0]  acc_size = 3'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [64];

    always #2.5 clk = ~clk;

    cfg_hdr_regs #(
        .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .CMD_INIT(T_CMD), .STAT_INIT(T_STAT),
        .REVISION(T_REV), .CLASS_CODE(T_CLASS), .CLS_INIT(8'h10), .LAT_INIT(8'h20),
        .HDR_TYPE(8'h00), .BIST_INIT(8'h00), .BAR_INIT(T_BINIT), .BAR_SIZE(T_BSZ),
        .CIS_INIT(32'h0000_0040), .SUBSYS_VID(16'hAA55), .SUBSYS_ID(16'h0102),
        .ROM_INIT(T_ROM), .INT_LINE(8'h0B), .INT_PIN(8'h01), .MIN_GNT(8'h03), .MAX_LAT(8'h09)
    ) u_cfg_hdr_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic void put16(int o, logic [15:0] v);
        model[o] = v[7:0]; model[o+1] = v[15:8];
    endfunction
    function automatic void put32(int o, logic [31:0] v);
        for (int b = 0; b < 4; b++) model[o+b] = v[8*b +: 8];
    endfunction
    function automatic logic [31:0] get32(int o);
        return {model[o+3], model[o+2], model[o+1], model[o]};
    endfunction

    function automatic void m_init();
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        put16(0, T_VID); put16(2, T_DID); put16(4, T_CMD); put16(6, T_STAT);
        model[8] = T_REV; model[9] = T_CLASS[7:0]; model[10] = T_CLASS[15:8]; model[11] = T_CLASS[23:16];
        model[12] = 8'h10; model[13] = 8'h20;
        for (int k = 0; k < 6; k++) put32(16 + 4*k, T_BINIT[32*k +: 32]);
        put32(8'h28, 32'h0000_0040); put16(8'h2C, 16'hAA55); put16(8'h2E, 16'h0102);
        put32(8'h30, T_ROM);
        model[60] = 8'h0B; model[61] = 8'h01; model[62] = 8'h03; model[63] = 8'h09;
    endfunction

    function automatic bit size_ok(int sz);
        return (sz == 1 || sz == 2 || sz == 4);
    endfunction

    function automatic logic [31:0] m_read(int off, int sz);
        logic [31:0] r = 32'h0;
        if (!size_ok(sz)) return 32'h0;
        for (int i = 0; i < sz; i++)
            if (off + i < 64) r[8*i +: 8] = model[off+i];
        return r;
    endfunction

    // returns error flag; updates model when accepted
    function automatic bit m_write(int off, int sz, logic [31:0] d);
        if (sz == 1 && (off == 8'h3C || off == 8'h0C)) begin
            model[off] = d[7:0]; return 1'b0;
        end
        if (sz == 2 && (off == 4 || off == 6 || off == 8'h0C)) begin
            put16(off, d[15:0]); return 1'b0;
        end
        if (sz == 4 && off >= 8'h10 && off < 8'h28 && off % 4 == 0) begin
            logic [31:0] old, tm, src;
            old = get32(off);
            tm  = old[0] ? 32'h3 : 32'hF;
            src = (d == 32'hFFFF_FFFF) ? ~(T_BSZ[32*((off-16)/4) +: 32] - 32'd1) : d;
            put32(off, (src & ~tm) | (old & tm));
            return 1'b0;
        end
        if (sz == 4 && off == 8'h30) begin
            put32(off, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d); return 1'b0;
        end
        if (sz == 4 && off == 4) begin
            put16(4, d[15:0]); return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    logic        got_v;
    logic [31:0] got_d;
    logic        got_e;

    task automatic access(bit we, int off, int sz, logic [31:0] d);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = we;
        acc_offset = 8'(off);
        acc_size   = 3'(sz);
        acc_wdata  = d;
        @(negedge clk);
        got_v = rsp_valid; got_d = rsp_rdata; got_e = rsp_err;
        acc_valid = 1'b0;
    endtask

    task automatic do_rd(int off, int sz, string req);
        logic [31:0] e;
        bit ee;
        e  = m_read(off, sz);
        ee = !size_ok(sz);
        access(1'b0, off, sz, 32'h0);
        chk(got_v == 1'b1, req, {31'h0, got_v}, 32'h1);
        chk(got_d == e && got_e == ee, req, got_d, e);
    endtask

    task automatic do_wr(int off, int sz, logic [31:0] d, string req);
        bit ee;
        ee = m_write(off, sz, d);
        if (!size_ok(sz)) ee = 1'b1;
        access(1'b1, off, sz, d);
        chk(got_v == 1'b1 && got_d == 32'h0, req, got_d, 32'h0);
        chk(got_e == ee, req, {31'h0, got_e}, {31'h0, ee});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_init();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 reset idle", {31'h0, rsp_valid}, 32'h0);

        // R1 reset contents
        for (int o = 0; o < 64; o += 4) do_rd(o, 4, "R1 reset word");
        access(1'b0, 0, 4, 32'h0);
        chk(got_d == 32'h3C4D_1A2B, "R1 identity", got_d, 32'h3C4D_1A2B);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle after response", {31'h0, rsp_valid}, 32'h0);

        // R2 lanes and end of header
        do_rd(8'h3E, 4, "R2 straddle end");
        do_rd(8'h09, 2, "R2 halfword lanes");
        do_rd(8'h0B, 1, "R2 byte lane");
        do_rd(70, 4, "R2 beyond end");

        // R7 probes
        do_wr(8'h10, 4, 32'hFFFF_FFFF, "R7 probe mem");
        do_rd(8'h10, 4, "R7 readback mem");
        chk(got_d == 32'hFFFF_F008, "R7 mem mask", got_d, 32'hFFFF_F008);
        do_wr(8'h14, 4, 32'hFFFF_FFFF, "R7 probe io");
        do_rd(8'h14, 4, "R7 readback io");
        chk(got_d == 32'hFFFF_FFE1, "R7 io mask", got_d, 32'hFFFF_FFE1);

        // R6 normal writes keep type bits
        do_wr(8'h10, 4, 32'h1234_5677, "R6 mem write");
        do_rd(8'h10, 4, "R6 readback");
        chk(got_d == 32'h1234_5678, "R6 type kept", got_d, 32'h1234_5678);
        do_wr(8'h14, 4, 32'h0000_C002, "R6 io write");
        do_rd(8'h14, 4, "R6 io readback");

        // R8 ROM
        do_wr(8'h30, 4, 32'hFFFF_FFFE, "R8 rom probe");
        do_rd(8'h30, 4, "R8 rom read");
        chk(got_d == 32'hFFFF_FFFF, "R8 rom all ones", got_d, 32'hFFFF_FFFF);
        do_wr(8'h30, 4, 32'hABCD_0001, "R8 rom store");
        do_rd(8'h30, 4, "R8 rom read2");

        // R5 command word
        do_wr(8'h04, 4, 32'hDEAD_BEEF, "R5 command word");
        do_rd(8'h04, 4, "R5 status kept");
        chk(got_d == {T_STAT, 16'hBEEF}, "R5 status kept", got_d, {T_STAT, 16'hBEEF});

        // R3 / R4
        do_wr(8'h3C, 1, 32'h0000_005A, "R3 int line");
        do_wr(8'h3D, 1, 32'h0000_0077, "R3 pin refused");
        do_rd(8'h3C, 2, "R3 readback");
        do_wr(8'h0C, 2, 32'h0000_7788, "R4 cls half");
        do_rd(8'h0C, 2, "R4 readback");
        chk(got_d == 32'h0000_7788, "R4 two bytes", got_d, 32'h0000_7788);
        do_wr(8'h06, 2, 32'h0000_1111, "R4 status half");
        do_wr(8'h08, 2, 32'h0000_2222, "R4 refused");

        // R9 / R10 / R11
        do_wr(8'h00, 4, 32'h0, "R9 id refused");
        do_rd(8'h00, 4, "R9 id kept");
        do_wr(8'h12, 4, 32'hFFFF_FFFF, "R9 misaligned bar");
        do_wr(70, 1, 32'h0, "R9 beyond end");
        do_wr(8'h3C, 3, 32'h0, "R10 size3 write");
        do_rd(8'h00, 3, "R10 size3 read");
        do_rd(8'h00, 0, "R10 size0 read");
        do_wr(8'h30, 4, 32'h1, "R11 accepted write");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int off, sz, pick;
            logic [31:0] d;
            pick = int'($urandom % 4);
            if (pick == 0) begin
                case ($urandom % 9)
                    0: off = 8'h04; 1: off = 8'h06; 2: off = 8'h0C; 3: off = 8'h3C;
                    4: off = 8'h30; default: off = 8'h10 + 4 * int'($urandom % 6);
                endcase
            end else begin
                off = int'($urandom % 80);
            end
            case ($urandom % 6)
                0: sz = 1; 1: sz = 2; 2, 3: sz = 4; 4: sz = 3; default: sz = 0;
            endcase
            case ($urandom % 8)
                0: d = 32'hFFFF_FFFF; 1: d = 32'hFFFF_FFFE; default: d = $urandom;
            endcase
            if ($urandom % 2 == 0) do_wr(off, sz, d, "R9 random write");
            else do_rd(off, sz, "R2 random read");
        end

        for (int o = 0; o < 64; o += 4) do_rd(o, 4, "R9 final sweep");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule